// File: doc/BRIEF.md
# Two-Stage Square-Wave Frequency Synthesizer

This block produces square waves in two stages. The fine stage is a 32-bit phase accumulator. It runs on a fast system clock and adds a programmable tuning word on every edge. The accumulator's top bit is the fine square wave, and its frequency is tuning_word × F_acc / 2^32. With a 200 MHz accumulator clock, the tuning word is chosen so that this output lands between 6.25 MHz and 12.5 MHz. That range lets an external clock multiplier accept it and clean it.

The coarse stage runs on a second clock input, which is the multiplied and cleaned fine output. A free-running binary counter advances on that clock. A registered 5-bit select D picks one counter bit as the coarse output, so the coarse stage divides its clock by 2^(D+1). Each stage has its own synchronous active-high reset. The block contains no state machine: its only state is the two registered datapaths.

Top module: `dds_two_stage_synth`

## Requirements
- R1: Each rising edge of clk_acc without reset adds the captured tuning word to the 32-bit accumulator, wrapping modulo 2^32. With a constant word N applied from reset release, the accumulator holds (k-1)·N mod 2^32 after the k-th edge.
- R2: fine_out is bit 31 of the accumulator. Over 65536 clk_acc cycles, the number of fine_out rising edges differs from N·65536/2^32 by less than one.
- R3: tune_word is captured into a register on one clk_acc edge and added on the next. With N = 2^31 driven at reset release, fine_out is low after edge 1, high after edge 2, and then alternates on every edge.
- R4: With N = 204010946 (a frequency inside the 6.25 to 12.5 MHz band at 200 MHz), every complete high phase and every complete low phase of fine_out lasts 10 or 11 clk_acc cycles.
- R5: While rst_acc is high at a clk_acc edge, both the accumulator and the captured word clear to zero and fine_out goes low. With tune_word = 0, fine_out stays low indefinitely.
- R6: The coarse counter increments by one on every clk_div edge without reset.
- R7: coarse_out is counter bit D. It is periodic with a period of 2^(D+1) clk_div cycles and a high phase of 2^D cycles.
- R8: div_sel is registered in the clk_div domain, and coarse_out is driven straight from a flip-flop.
- R9: While rst_div is high at a clk_div edge, the counter clears to zero and coarse_out goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_acc | input | 1 | Accumulator clock |
| rst_acc | input | 1 | Synchronous active-high reset, accumulator domain |
| tune_word | input | 32 | Phase increment N |
| fine_out | output | 1 | Accumulator MSB square wave |
| clk_div | input | 1 | Divider clock (cleaned, multiplied fine output) |
| rst_div | input | 1 | Synchronous active-high reset, divider domain |
| div_sel | input | 5 | Coarse select D, divide by 2^(D+1) |
| coarse_out | output | 1 | Divided square wave |

## Verification
The assertions assume that each domain sees at least one edge with its reset high before any check counts. They also assume that tune_word and div_sel change only away from their own clock's rising edge, so each captured value is exactly the one presented before that edge. The bench always starts a domain with a reset pulse and drives every input shortly after a rising edge. For each divider measurement it pulses rst_div, so the counter restarts from zero under a freshly registered select.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
    localparam int unsigned ACC_W_DEF = 32;
    localparam int unsigned CNT_W_DEF = 32;

    function automatic int unsigned sel_bits(input int unsigned width);
        return (width <= 1) ? 1 : $clog2(width);
    endfunction
endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] tune_in,
    output logic             msb_out
);
    localparam int unsigned MSB = ACC_W - 1;

    logic [ACC_W-1:0] tune_q;
    logic [ACC_W-1:0] acc_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tune_q  <= '0;
            acc_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            tune_q  <= tune_in;
            acc_q   <= acc_q + tune_q;
            armed_q <= 1'b1;
        end
    end

    assign msb_out = acc_q[MSB];

    // R1: accumulator advances by the previously captured word
    p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> acc_q == $past(acc_q) + $past(tune_q));

    // R3: captured word equals the input presented one edge earlier
    p_tune_capture_r3: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> tune_q == $past(tune_in));

    // R5: a reset edge leaves accumulator, captured word and output cleared
    p_acc_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_q == '0 && tune_q == '0 && !msb_out));
endmodule

// File: rtl/dds_pow2_div.sv
`timescale 1ns/1ps
module dds_pow2_div #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_in,
    output logic             div_out
);
    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic             out_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            sel_q   <= '0;
            out_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            sel_q   <= sel_in;
            out_q   <= cnt_q[sel_q];
            armed_q <= 1'b1;
        end
    end

    assign div_out = out_q;

    // R6: free-running increment
    p_cnt_inc_r6: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> cnt_q == $past(cnt_q) + 1'b1);

    // R8: select register follows the input one edge later
    p_sel_reg_r8: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> sel_q == $past(sel_in));

    // R9: reset edge clears counter and output
    p_div_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt_q == '0 && !div_out));
endmodule

// File: rtl/dds_two_stage_synth.sv
`timescale 1ns/1ps
module dds_two_stage_synth #(
    parameter int unsigned ACC_W = dds_pkg::ACC_W_DEF,
    parameter int unsigned CNT_W = dds_pkg::CNT_W_DEF,
    parameter int unsigned SEL_W = dds_pkg::sel_bits(CNT_W)
) (
    input  logic             clk_acc,
    input  logic             rst_acc,
    input  logic [ACC_W-1:0] tune_word,
    output logic             fine_out,
    input  logic             clk_div,
    input  logic             rst_div,
    input  logic [SEL_W-1:0] div_sel,
    output logic             coarse_out
);
    dds_phase_acc #(
        .ACC_W (ACC_W)
    ) u_fine (
        .clk     (clk_acc),
        .rst     (rst_acc),
        .tune_in (tune_word),
        .msb_out (fine_out)
    );

    dds_pow2_div #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_coarse (
        .clk     (clk_div),
        .rst     (rst_div),
        .sel_in  (div_sel),
        .div_out (coarse_out)
    );
endmodule

// File: tb/sim_dds_two_stage_synth.sv
`timescale 1ns/1ps
module sim_dds_two_stage_synth;
    logic        clk_a = 1'b0;
    logic        clk_d = 1'b0;
    logic        rst_a = 1'b1;
    logic        rst_d = 1'b1;
    logic [31:0] tune  = '0;
    logic [4:0]  dsel  = '0;
    logic        fine;
    logic        coarse;

    always #2.5 clk_a = ~clk_a;
    always #2   clk_d = ~clk_d;

    dds_two_stage_synth u0 (
        .clk_acc    (clk_a),
        .rst_acc    (rst_a),
        .tune_word  (tune),
        .fine_out   (fine),
        .clk_div    (clk_d),
        .rst_div    (rst_d),
        .div_sel    (dsel),
        .coarse_out (coarse)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard for coarse periods
    int unsigned exp_q[$];
    bit          meas_req = 1'b0;
    int unsigned since_rise = 0;
    int unsigned hi_seen = 0;
    int          rises = 0;
    logic        prev_c = 1'b0;

    always @(negedge clk_d) begin
        if (rst_d) begin
            since_rise = 0;
            rises      = 0;
            prev_c     = 1'b0;
        end else begin
            since_rise++;
            if (!meas_req) rises = 0;
            if (!coarse && prev_c) hi_seen = since_rise;
            if (coarse && !prev_c) begin
                if (meas_req) begin
                    rises++;
                    if (rises >= 2) begin
                        int unsigned e;
                        e = exp_q.pop_front();
                        check(since_rise == e, "R7/R6 coarse period", since_rise, e);
                        meas_req = 1'b0;
                    end
                end
                since_rise = 0;
            end
            prev_c = coarse;
        end
    end

    task automatic acc_restart(input logic [31:0] n);
        @(posedge clk_a); #1 rst_a = 1'b1;
        @(posedge clk_a); #1 rst_a = 1'b0; tune = n;
    endtask

    // compares fine_out after each edge with bit 31 of (k-1)*N
    task automatic acc_pattern(input logic [31:0] n, input int edges, input string req);
        int bad = 0;
        logic [31:0] model = '0;
        logic got = 1'b0;
        acc_restart(n);
        for (int k = 1; k <= edges; k++) begin
            @(posedge clk_a); @(negedge clk_a);
            if (fine !== model[31] && bad == 0) got = fine;
            if (fine !== model[31]) bad++;
            model = model + n;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic div_run(input int d);
        @(posedge clk_d); #1 dsel = d[4:0]; rst_d = 1'b1;
        @(posedge clk_d); @(posedge clk_d); #1 rst_d = 1'b0;
        check(coarse == 1'b0, "R9 coarse low after reset", coarse, 0);
        exp_q.push_back(32'd1 << (d + 1));
        meas_req = 1'b1;
        while (meas_req) @(negedge clk_d);
        check(hi_seen == (32'd1 << d), "R7 coarse high phase", hi_seen, 32'd1 << d);
    endtask

    initial begin
        repeat (3) @(posedge clk_a);
        @(negedge clk_a);
        check(fine == 1'b0, "R5 fine low in reset", fine, 0);
        @(posedge clk_d); @(negedge clk_d);
        check(coarse == 1'b0, "R9 coarse low in reset", coarse, 0);

        // R5: zero word keeps output low
        begin
            int highs = 0;
            acc_restart(32'd0);
            for (int k = 0; k < 100; k++) begin
                @(negedge clk_a);
                if (fine) highs++;
            end
            check(highs == 0, "R5 zero word output stays low", highs, 0);
        end

        // R3: capture then add latency, N = 2^31
        acc_restart(32'h8000_0000);
        @(posedge clk_a); @(negedge clk_a);
        check(fine == 1'b0, "R3 low after edge 1", fine, 0);
        @(posedge clk_a); @(negedge clk_a);
        check(fine == 1'b1, "R3 high after edge 2", fine, 1);
        @(posedge clk_a); @(negedge clk_a);
        check(fine == 1'b0, "R3 low after edge 3", fine, 0);

        // R1: accumulate patterns
        acc_pattern(32'h4000_0000, 24, "R1 quarter-word pattern");
        acc_pattern(32'h5A5A_5A5B, 64, "R1 irregular word with wrap");
        acc_pattern(32'hFFFF_FFFF, 40, "R1 maximum word wrap");

        // R2 and R4: edge count and phase lengths
        begin
            int   rcount = 0;
            int   run    = 0;
            int   minrun = 1000;
            int   maxrun = 0;
            bit   started = 1'b0;
            logic pv = 1'b0;
            real  ideal;
            real  diff;
            acc_restart(32'd204010946);
            for (int k = 0; k < 65536; k++) begin
                @(posedge clk_a); @(negedge clk_a);
                run++;
                if (fine !== pv) begin
                    if (started) begin
                        if (run < minrun) minrun = run;
                        if (run > maxrun) maxrun = run;
                    end
                    if (fine && !pv) rcount++;
                    started = 1'b1;
                    run = 0;
                end
                pv = fine;
            end
            ideal = real'(204010946) * 65536.0 / 4294967296.0;
            diff  = real'(rcount) - ideal;
            if (diff < 0.0) diff = -diff;
            check(diff < 1.0, "R2 rising edges in 65536 cycles", rcount, $rtoi(ideal));
            check(minrun >= 10, "R4 shortest phase", minrun, 10);
            check(maxrun <= 11, "R4 longest phase", maxrun, 11);
        end

        // R6 R7 R8 R9: coarse divider through the scoreboard
        div_run(0);
        div_run(1);
        div_run(4);
        div_run(7);
        div_run(10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule